// File: doc/BRIEF.md
# Quadrature Sine Sample Generator

This block feeds a pair of 12-bit DAC channels with two sine waves a quarter period apart. A free-running phase index walks a 64-sample sine table, one step per sample interval. A second read of the same table, taken 16 places ahead of the first, yields a quadrature wave that leads the main wave by 90 degrees.

Each new pair of codes is first captured in staging registers. On the following clock edge both codes move to the output registers together, so the two channels never sit one sample apart. A one-cycle strobe marks each transfer. An indicator bit shows the top bit of the main code, which is high while the main wave is in its upper half. An enable input freezes the sample timer. While the enable is low, both outputs keep their last committed codes.

Top module: `quad_sine_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state has `main_o` = 0x800, `quad_o` = 0xFFF, `upd_o` = 0 and `ind_o` = 1. The phase index and the interval counter both return to 0.
- R2: The table has 64 twelve-bit entries. Entries 0..16 are, in order, 7FF 8C8 98E A51 B0F BC4 C71 D12 DA7 E2E EA5 F0D F63 FA6 FD7 FF5 FFF (hex). Entry 32-k equals entry k for k in 0..16. Entry 32+k equals 0xFFE minus entry k for k in 1..15, with the same rule mirrored for entries 49..63. Entry 48 is 0x000.
- R3: Each committed `quad_o` is the table entry at (main index + 16) mod 64.
- R4: The main index of the first commit after reset is 0. Each later commit advances it by one, and 63 is followed by 0.
- R5: A new pair is staged after every TICKS clock edges at which `en_i` is high. `upd_o` is high for exactly one cycle per committed pair.
- R6: `main_o` and `quad_o` change only in the cycle in which `upd_o` is high, and both take their new values on the same edge.
- R7: While `en_i` is low, the interval counter holds its value, no new pair is staged, and both outputs keep their values.
- R8: `ind_o` always equals bit 11 of `main_o`.
- R9: A pair is staged on the edge at which the counter completes its interval. It is committed on the next edge. With `en_i` held high from reset release, `upd_o` is first seen high after edge TICKS+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Lets the sample timer advance |
| main_o | output | 12 | Committed main-channel code |
| quad_o | output | 12 | Committed quadrature-channel code, 90 degrees ahead |
| upd_o | output | 1 | One-cycle pulse on each simultaneous commit |
| ind_o | output | 1 | Top bit of the committed main code |

## Verification
The bench builds the block with TICKS = 5 instead of the default 36. This makes one full 64-sample period take about 320 cycles, so a single run covers many index wraps, the 16-entry lead of the quadrature read across the 63-to-0 boundary, and both the peak and trough entries. Random enable patterns, a long idle stretch and a reset in the middle of the run bring the frozen-counter and restart behaviour within reach in a few thousand cycles.

// File: rtl/qsg_pkg.sv
// Package: shared constants, types and the quarter-wave sample list
// for the quadrature sine generator.
// Assumes a 64-entry, 12-bit table whose other quarters are folded
// from the first quarter.
package qsg_pkg;

    localparam int CODE_W  = 12;
    localparam int IDX_W   = 6;
    localparam int DEPTH   = 1 << IDX_W;
    localparam int QUARTER = DEPTH / 4;
    localparam int NCHAN   = 2;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [IDX_W-1:0]  idx_t;

    localparam code_t CODE_MID_RST = 12'h800;
    localparam code_t CODE_FULL    = 12'hFFF;
    localparam code_t CODE_FOLD    = 12'hFFE;

    // First quarter of the wave, k = 0..16 (rising from mid-scale to peak)
    function automatic code_t quarter_wave(input logic [4:0] k);
        code_t v;
        case (k)
            5'd0:    v = 12'h7FF;
            5'd1:    v = 12'h8C8;
            5'd2:    v = 12'h98E;
            5'd3:    v = 12'hA51;
            5'd4:    v = 12'hB0F;
            5'd5:    v = 12'hBC4;
            5'd6:    v = 12'hC71;
            5'd7:    v = 12'hD12;
            5'd8:    v = 12'hDA7;
            5'd9:    v = 12'hE2E;
            5'd10:   v = 12'hEA5;
            5'd11:   v = 12'hF0D;
            5'd12:   v = 12'hF63;
            5'd13:   v = 12'hFA6;
            5'd14:   v = 12'hFD7;
            5'd15:   v = 12'hFF5;
            default: v = 12'hFFF;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/qsg_rom.sv
// Module: qsg_rom
// Purely combinational 64-entry sine lookup built from the quarter wave.
// Assumes a 6-bit address: bit 5 selects the lower half-wave and bit 4
// selects the falling quarter within a half.
module qsg_rom
    import qsg_pkg::*;
(
    input  idx_t  addr,
    output code_t code
);

    logic [4:0] fold_k;
    code_t      q_val;

    // Mirror the address into the 0..16 quarter range
    always_comb begin
        if (addr[4]) begin
            fold_k = 5'(6'd32 - {1'b0, addr[4:0]});
        end else begin
            fold_k = addr[4:0];
        end
    end

    // Look up the quarter sample and flip it for the lower half-wave
    always_comb begin
        q_val = quarter_wave(fold_k);
        if (addr[5]) begin
            code = (q_val == CODE_FULL) ? '0 : (CODE_FOLD - q_val);
        end else begin
            code = q_val;
        end
    end

endmodule

// File: rtl/qsg_timer.sv
// Module: qsg_timer
// Counts enabled cycles, raises a one-cycle strobe every TICKS of
// them, and steps the main phase index on each strobe.
// Assumes TICKS >= 2. The index wraps naturally at 2**IDX_W.
module qsg_timer
    import qsg_pkg::*;
#(
    parameter int TICKS = 36
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic strobe_o,
    output idx_t idx_o
);

    localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    // Strobe when an enabled cycle completes the interval
    always_comb begin
        strobe_o = en_i && (cnt_q == CNT_LAST);
    end

    // Interval counter: advance on enable, reload to zero after the last tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (strobe_o) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Phase index: one step per strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_o <= '0;
        end else if (strobe_o) begin
            idx_o <= idx_o + 1'b1;
        end
    end

endmodule

// File: rtl/qsg_stage.sv
// Module: qsg_stage
// Two-step transfer: new codes are captured in staging registers on a
// load pulse, then moved to both outputs together on the next edge.
// Assumes load pulses are at least two cycles apart.
module qsg_stage
    import qsg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  code_t main_d,
    input  code_t quad_d,
    output code_t main_q,
    output code_t quad_q,
    output logic  upd_o
);

    code_t stg_main;
    code_t stg_quad;
    logic  stg_vld;

    // Capture the pair coming from the lookup
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_main <= CODE_MID_RST;
            stg_quad <= CODE_FULL;
            stg_vld  <= 1'b0;
        end else begin
            stg_vld <= load_i;
            if (load_i) begin
                stg_main <= main_d;
                stg_quad <= quad_d;
            end
        end
    end

    // Commit both staged codes to the outputs on one edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_q <= CODE_MID_RST;
            quad_q <= CODE_FULL;
            upd_o  <= 1'b0;
        end else begin
            upd_o <= stg_vld;
            if (stg_vld) begin
                main_q <= stg_main;
                quad_q <= stg_quad;
            end
        end
    end

endmodule

// File: rtl/quad_sine_gen.sv
// Module: quad_sine_gen (top)
// Two sine streams 90 degrees apart for a DAC pair, committed together.
// Channel 0 reads the table at the phase index and channel 1 reads it a
// quarter table ahead. Assumes TICKS >= 2.
module quad_sine_gen
    import qsg_pkg::*;
#(
    parameter int TICKS = 36
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_i,
    output logic [11:0] main_o,
    output logic [11:0] quad_o,
    output logic        upd_o,
    output logic        ind_o
);

    logic  strobe;
    idx_t  phase_idx;
    code_t chan_code [NCHAN];

    qsg_timer #(.TICKS(TICKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .strobe_o (strobe),
        .idx_o    (phase_idx)
    );

    // One lookup per channel, each offset by a quarter table
    for (genvar ch = 0; ch < NCHAN; ch++) begin : g_chan
        localparam idx_t OFS = idx_t'(ch * QUARTER);
        idx_t rd_addr;

        // Offset read address, wrapping modulo the table depth
        always_comb begin
            rd_addr = phase_idx + OFS;
        end

        qsg_rom u_rom (
            .addr (rd_addr),
            .code (chan_code[ch])
        );
    end

    qsg_stage u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (strobe),
        .main_d (chan_code[0]),
        .quad_d (chan_code[1]),
        .main_q (main_o),
        .quad_q (quad_o),
        .upd_o  (upd_o)
    );

    // Indicator follows the sign half of the committed main code
    always_comb begin
        ind_o = main_o[CODE_W-1];
    end

endmodule

// File: rtl/qsg_checker.sv
// Module: qsg_checker
// Port-level properties of quad_sine_gen, bound to every instance.
// Assumes TICKS >= 2, so update pulses never abut.
module qsg_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        en_i,
    input logic [11:0] main_o,
    input logic [11:0] quad_o,
    input logic        upd_o,
    input logic        ind_o
);

    // R1: reset forces the documented output state
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (main_o == 12'h800 && quad_o == 12'hFFF && !upd_o));

    // R5: the update pulse lasts a single cycle
    assert_upd_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o);

    // R6: the main code moves only with an update
    assert_main_on_upd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(main_o) |-> upd_o);

    // R6: the quadrature code moves only with an update
    assert_quad_on_upd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(quad_o) |-> upd_o);

    // R7: no commit can follow an edge at which enable was low
    assert_idle_no_upd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i, 2) |-> !upd_o);

    // R8: the indicator tracks the main code's top bit
    assert_ind_msb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ind_o == main_o[11]);

endmodule

bind quad_sine_gen qsg_checker u_qsg_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_i),
    .main_o (main_o),
    .quad_o (quad_o),
    .upd_o  (upd_o),
    .ind_o  (ind_o)
);

// File: tb/quad_sine_gen_test.sv
module quad_sine_gen_test;

    localparam int TICKS = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic [11:0] main_o, quad_o;
    logic        upd_o, ind_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit idle_chk = 1'b0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    quad_sine_gen #(.TICKS(TICKS)) uut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i),
        .main_o(main_o), .quad_o(quad_o), .upd_o(upd_o), .ind_o(ind_o)
    );

    // Reference sample: table entry computed from the quarter list (R2)
    function automatic logic [11:0] ref_entry(input int i);
        logic [11:0] qw [17];
        int j;
        qw = '{12'h7FF, 12'h8C8, 12'h98E, 12'hA51, 12'hB0F, 12'hBC4,
               12'hC71, 12'hD12, 12'hDA7, 12'hE2E, 12'hEA5, 12'hF0D,
               12'hF63, 12'hFA6, 12'hFD7, 12'hFF5, 12'hFFF};
        j = i % 64;
        if (j <= 16)      return qw[j];
        else if (j <= 32) return qw[32 - j];
        else if (j == 48) return 12'h000;
        else if (j < 48)  return 12'hFFE - qw[j - 32];
        else              return 12'hFFE - qw[64 - j];
    endfunction

    // Reference model of timing and index, from R4, R5, R7, R9
    int          m_cnt, m_idx, m_stg_idx;
    bit          m_vld;
    logic [11:0] exp_main, exp_quad;
    logic        exp_upd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0; m_idx <= 0; m_vld <= 0; m_stg_idx <= 0;
            exp_main <= 12'h800; exp_quad <= 12'hFFF; exp_upd <= 1'b0;
        end else begin
            m_vld <= 1'b0;
            if (en_i) begin
                if (m_cnt == TICKS - 1) begin
                    m_cnt <= 0;
                    m_stg_idx <= m_idx;
                    m_idx <= (m_idx + 1) % 64;
                    m_vld <= 1'b1;
                end else begin
                    m_cnt <= m_cnt + 1;
                end
            end
            exp_upd <= m_vld;
            if (m_vld) begin
                exp_main <= ref_entry(m_stg_idx);
                exp_quad <= ref_entry(m_stg_idx + 16);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Compare every output against the model away from the clock edge
    logic [11:0] hold_main, hold_quad;
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            check(main_o == exp_main, "R2,R4 main", main_o, exp_main);
            check(quad_o == exp_quad, "R3 quad", quad_o, exp_quad);
            check(upd_o == exp_upd, "R5 upd", upd_o, exp_upd);
            check(ind_o == exp_main[11], "R8 ind", ind_o, exp_main[11]);
            if (idle_chk) begin
                check(main_o == hold_main, "R7 main hold", main_o, hold_main);
                check(quad_o == hold_quad, "R7 quad hold", quad_o, hold_quad);
                check(upd_o == 1'b0, "R7 no upd", upd_o, 0);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 200000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 200000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic reset_check();
        @(negedge clk);
        check(main_o == 12'h800, "R1 main", main_o, 12'h800);
        check(quad_o == 12'hFFF, "R1 quad", quad_o, 12'hFFF);
        check(upd_o == 1'b0, "R1 upd", upd_o, 0);
        check(ind_o == 1'b1, "R1 ind", ind_o, 1);
    endtask

    initial begin
        int first_upd;
        int seen_peak;
        int seed;
        seed = $urandom(32'd1234);
        rst_n = 1'b0; en_i = 1'b0;
        repeat (3) @(negedge clk);
        reset_check();

        // R9: first commit latency with enable held high
        rst_n = 1'b1; en_i = 1'b1;
        first_upd = 0;
        for (int e = 1; e <= TICKS + 4; e++) begin
            @(negedge clk);
            if (upd_o && first_upd == 0) first_upd = e;
        end
        check(first_upd == TICKS + 1, "R9 first commit edge", first_upd, TICKS + 1);

        // R2, R3: at the first commit main is 0x7FF and quad leads at 0xFFF
        // (verified by the model; also directed peak check below)
        seen_peak = 0;
        for (int c = 0; c < 64 * TICKS * 2; c++) begin
            @(negedge clk);
            if (upd_o && main_o == 12'hFFF && quad_o == ref_entry(32)) seen_peak++;
        end
        check(seen_peak == 2, "R2,R3 peak with quad at entry 32", seen_peak, 2);

        // Random enable patterns
        for (int c = 0; c < 2500; c++) begin
            en_i = (($urandom() % 10) < 7);
            @(negedge clk);
        end

        // R7: long idle stretch; wait out any pending commit first
        en_i = 1'b0;
        repeat (3) @(negedge clk);
        hold_main = main_o; hold_quad = quad_o;
        idle_chk = 1'b1;
        repeat (60) @(negedge clk);
        idle_chk = 1'b0;

        // Resume, then reset in mid-run
        en_i = 1'b1;
        repeat (137) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        reset_check();
        rst_n = 1'b1;
        for (int c = 0; c < 400; c++) begin
            en_i = (($urandom() % 4) != 0);
            @(negedge clk);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule